// File: doc/BRIEF.md
# Optical Module Port Status Monitor

This block watches the sideband pins of two pluggable optical module cages. For each cage it brings the receive-loss, transmit-fault and module-absent pins, and the link-up indication from the port's MAC, into the local clock domain through a two-flop synchroniser. A history flop then lets it find every toggle of the synchronised pins. A toggle of one of the three module pins sets a sticky change flag. Each flag stays set until a read of that port's status word.

Software reads one port at a time. It drives `rdEn` for one cycle with the port number on `rdPort`, and on the next cycle `rdValid` rises with the 32-bit status word on `rdData`. The read clears that port's change flags. A toggle detected in the same cycle as the read is kept, so it appears in the next read. The module-absent pin is high when the cage is empty, and a falling edge on it means a module was inserted.

Top module: `optmon_status`

## Requirements
- R1: Status word bit 0 is the synchronised receive-loss pin, bit 1 is the synchronised transmit-fault pin and bit 2 is the synchronised module-absent pin (1 = cage empty). A pin value stable before clock edge k is shown from edge k+2 on.
- R2: Bits 3, 4 and 5 are sticky change flags for receive-loss, transmit-fault and module-absent. Any toggle of the matching synchronised pin sets the flag, and the flag becomes visible in the same cycle as the new pin value.
- R3: A read of port P clears the change flags of port P only. The other port's flags are untouched.
- R4: A toggle detected in the same cycle as a read of its port is not lost. The read returns the flag value from before the toggle, and the flag stays set afterwards.
- R5: Bit 16 is the synchronised link-up indication of the port, with the same latency as R1. It has no change flag.
- R6: Bits 6 to 15 and 17 to 31 of the status word are always zero.
- R7: `rdEn` high at edge k with `rdPort` = P gives `rdValid` = 1 after edge k for exactly one cycle, with `rdData` holding port P's word as it was before edge k. `rdData` is zero whenever `rdValid` is low.
- R8: While reset is low and just after it, `rdValid` and `rdData` are zero. No change flag is set while the synchroniser is filling after reset, even when pins sit high through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxLoss | input | 2 | Receive loss-of-signal pin per port (asynchronous) |
| txFault | input | 2 | Transmit fault pin per port (asynchronous) |
| modAbsent | input | 2 | Module-absent pin per port, high when empty (asynchronous) |
| linkUp | input | 2 | Link-up indication per port (asynchronous) |
| rdEn | input | 1 | One-cycle read request |
| rdPort | input | 1 | Port number of the read |
| rdValid | output | 1 | Read data valid, one cycle after the request |
| rdData | output | 32 | Status word of the read port, zero when not valid |

## Verification
The assertions assume that the reset is held for at least one clock edge at the start. They also assume that a pin holds still for at least one cycle between toggles, so the history flop never misses an edge. The stimulus changes pins and read requests only on the falling clock edge. During random traffic it toggles each pin in a given cycle with low probability, and it aims one directed toggle to land in the same cycle as a read of its port. A cycle-level reference model in the bench tracks the pin history and the sticky flags, and it predicts every read result.

// File: rtl/optmon_pkg.sv
package optmon_pkg;
  localparam int OM_PORTS  = 2;
  localparam int OM_PORT_W = (OM_PORTS > 1) ? $clog2(OM_PORTS) : 1;
  localparam int OM_PINS   = 4;   // rxLoss, txFault, modAbsent, linkUp
  localparam int OM_FLAGS  = 3;   // pins that carry a change flag
  localparam int OM_LINK_BIT = 16;

  typedef struct packed {
    logic                 armed;    // synchroniser filled, edges are real
    logic                 capture;  // latch a status word this cycle
    logic [OM_PORTS-1:0]  clr;      // per-port flag clear
    logic [OM_PORT_W-1:0] sel;      // port being read
  } ctlStrb_t;

  function automatic logic [31:0] mkWord(input logic [OM_PINS-1:0] live,
                                         input logic [OM_FLAGS-1:0] flags);
    logic [31:0] w;
    w = '0;
    w[OM_FLAGS-1:0]          = live[OM_FLAGS-1:0];
    w[2*OM_FLAGS-1:OM_FLAGS] = flags;
    w[OM_LINK_BIT]           = live[OM_PINS-1];
    return w;
  endfunction
endpackage

// File: rtl/optmon_ctrl.sv
module optmon_ctrl
  import optmon_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rdEn,
  input  logic [OM_PORT_W-1:0] rdPort,
  output ctlStrb_t             strb,
  output logic                 rdValid
);
  localparam int FILL   = SYNC_STAGES + 1;
  localparam int FILL_W = $clog2(FILL + 1);

  logic [FILL_W-1:0] fillQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillQ   <= '0;
      rdValid <= 1'b0;
    end else begin
      if (fillQ != FILL_W'(FILL)) fillQ <= fillQ + 1'b1;
      rdValid <= rdEn;
    end
  end

  always_comb begin
    strb         = '0;
    strb.armed   = (fillQ == FILL_W'(FILL));
    strb.capture = rdEn;
    strb.sel     = rdPort;
    for (int p = 0; p < OM_PORTS; p++)
      strb.clr[p] = rdEn && (rdPort == OM_PORT_W'(p));
  end

  // R3: at most one port cleared per cycle
  p_clr_onehot_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.clr));
endmodule

// File: rtl/optmon_datapath.sv
module optmon_datapath
  import optmon_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [OM_PORTS-1:0][OM_PINS-1:0] pinIn,
  input  ctlStrb_t                         strb,
  output logic [31:0]                      rdData
);
  localparam int NB   = OM_PORTS * OM_PINS;
  localparam int LAST = SYNC_STAGES - 1;

  logic [NB-1:0] syncQ [SYNC_STAGES];
  logic [NB-1:0] liveQ;
  logic [OM_PORTS-1:0][OM_FLAGS-1:0] stickyQ;
  logic [OM_PORTS-1:0][OM_FLAGS-1:0] chg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
      liveQ <= '0;
    end else begin
      syncQ[0] <= pinIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
      liveQ <= syncQ[LAST];
    end
  end

  for (genvar p = 0; p < OM_PORTS; p++) begin : g_port
    assign chg[p] = strb.armed ?
      (syncQ[LAST][p*OM_PINS +: OM_FLAGS] ^ liveQ[p*OM_PINS +: OM_FLAGS]) : '0;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stickyQ[p] <= '0;
      else       stickyQ[p] <= (stickyQ[p] & ~{OM_FLAGS{strb.clr[p]}}) | chg[p];
    end

    // R3: a flag only drops after a read of its own port
    p_flag_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
      (($past(stickyQ[p]) & ~stickyQ[p]) != '0) |-> $past(strb.clr[p]));
    // R2: a visible live change comes with its flag set
    p_flag_tracks_live_r2: assert property (@(posedge clk) disable iff (!rstN)
      $past(strb.armed) |->
        (((liveQ[p*OM_PINS +: OM_FLAGS] ^ $past(liveQ[p*OM_PINS +: OM_FLAGS]))
          & ~stickyQ[p]) == '0));
    // R4: a toggle coinciding with a read survives it
    p_keep_on_read_r4: assert property (@(posedge clk) disable iff (!rstN)
      $past(strb.clr[p] && (chg[p] != '0)) |-> ((stickyQ[p] & $past(chg[p])) == $past(chg[p])));
    // R8: no flags while the synchroniser fills
    p_quiet_fill_r8: assert property (@(posedge clk) disable iff (!rstN)
      !strb.armed |-> (stickyQ[p] == '0));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rdData <= '0;
    else if (strb.capture) rdData <= mkWord(liveQ[strb.sel*OM_PINS +: OM_PINS], stickyQ[strb.sel]);
    else                   rdData <= '0;
  end
endmodule

// File: rtl/optmon_status.sv
module optmon_status
  import optmon_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [OM_PORTS-1:0]  rxLoss,
  input  logic [OM_PORTS-1:0]  txFault,
  input  logic [OM_PORTS-1:0]  modAbsent,
  input  logic [OM_PORTS-1:0]  linkUp,
  input  logic                 rdEn,
  input  logic [OM_PORT_W-1:0] rdPort,
  output logic                 rdValid,
  output logic [31:0]          rdData
);
  ctlStrb_t strb;
  logic [OM_PORTS-1:0][OM_PINS-1:0] pinIn;

  always_comb
    for (int p = 0; p < OM_PORTS; p++)
      pinIn[p] = {linkUp[p], modAbsent[p], txFault[p], rxLoss[p]};

  optmon_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdPort(rdPort),
    .strb(strb), .rdValid(rdValid));

  optmon_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .strb(strb), .rdData(rdData));

  // R6: unused bits stay zero
  p_reserved_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[15:6] == '0) && (rdData[31:17] == '0));
  // R7: data only alongside valid
  p_idle_data_r7: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> (rdData == '0));
  // R7: valid only answers a request
  p_valid_answers_r7: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(rdEn));
endmodule

// File: tb/optmon_status_tb.sv
module optmon_status_tb;
  localparam int LAT = 2;            // synchroniser depth assumed by the model
  localparam int HIST = LAT + 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] rxLoss = '0, txFault = '0, modAbsent = '0, linkUp = '0;
  logic rdEn = 1'b0;
  logic rdPort = 1'b0;
  logic rdValid;
  logic [31:0] rdData;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;   // 250 MHz

  optmon_status u_dut (
    .clk(clk), .rstN(rstN), .rxLoss(rxLoss), .txFault(txFault),
    .modAbsent(modAbsent), .linkUp(linkUp), .rdEn(rdEn), .rdPort(rdPort),
    .rdValid(rdValid), .rdData(rdData));

  // ---------------- reference model ----------------
  bit [3:0] hist [2][$];
  bit [3:0] live [2];
  bit [2:0] sticky [2];
  bit        expValid;
  bit [31:0] expData;

  function automatic bit [31:0] word(bit [3:0] l, bit [2:0] f);
    bit [31:0] w = 0;
    w[0] = l[0]; w[1] = l[1]; w[2] = l[2];
    w[3] = f[0]; w[4] = f[1]; w[5] = f[2];
    w[16] = l[3];
    return w;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int p = 0; p < 2; p++) begin
        hist[p].delete(); live[p] = 0; sticky[p] = 0;
      end
      expValid = 0; expData = 0;
    end else begin
      expValid = rdEn;
      expData  = rdEn ? word(live[rdPort], sticky[rdPort]) : 32'h0;
      for (int p = 0; p < 2; p++) begin
        bit [2:0] c;
        hist[p].push_front({linkUp[p], modAbsent[p], txFault[p], rxLoss[p]});
        if (hist[p].size() > HIST) void'(hist[p].pop_back());
        c = 0;
        if (hist[p].size() == HIST) c = hist[p][LAT][2:0] ^ hist[p][LAT+1][2:0];
        live[p] = (hist[p].size() > LAT) ? hist[p][LAT] : 4'h0;
        if (rdEn && rdPort == p) sticky[p] = 0;
        sticky[p] = sticky[p] | c;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk(rdValid == expValid, "R7 valid", 32'(rdValid), 32'(expValid));
      chk(rdData[2:0] == expData[2:0], "R1 live pins", rdData, expData);
      chk(rdData[5:3] == expData[5:3], "R2/R3/R4 change flags", rdData, expData);
      chk(rdData[16] == expData[16], "R5 link", rdData, expData);
      chk(rdData[15:6] == 0 && rdData[31:17] == 0, "R6 reserved", rdData, 32'h0);
    end
  end

  task automatic doRead(input bit port, output logic [31:0] d);
    @(negedge clk); rdEn = 1; rdPort = port;
    @(negedge clk); rdEn = 0; d = rdData;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] d;
    rxLoss = 2'b01; modAbsent = 2'b11;
    idle(4);
    // R8: outputs quiet in reset
    chk(rdValid == 0 && rdData == 0, "R8 reset outputs", rdData, 32'h0);
    rstN = 1;
    idle(6);
    doRead(0, d);
    chk(d[5:3] == 3'b000, "R8 no flags after fill", d, 32'h0);
    chk(d[2:0] == 3'b101, "R1 live rxLoss/modAbsent", d, 32'h5);

    // insertion on port 0, link up
    modAbsent[0] = 0; linkUp[0] = 1;
    idle(4);
    doRead(0, d);
    chk(d[5] == 1 && d[2] == 0, "R2 insertion flag", d, 32'h21);
    chk(d[16] == 1, "R5 link up", d, 32'h10000);
    doRead(0, d);
    chk(d[5:3] == 0, "R3 cleared by read", d, 32'h0);
    doRead(1, d);
    chk(d[5:3] == 0 && d[2] == 1, "R3 port1 untouched state", d, 32'h4);

    // R3: flag on port 1 survives a read of port 0
    txFault[1] = 1;
    idle(4);
    doRead(0, d);
    doRead(1, d);
    chk(d[4] == 1, "R3 other port flag kept", d, 32'h10);

    // R4: toggle lands on the read edge
    @(negedge clk); rxLoss[1] = 1;
    @(negedge clk);
    @(negedge clk); rdEn = 1; rdPort = 1;
    @(negedge clk); rdEn = 0; d = rdData;
    chk(d[3] == 0, "R4 read returns pre-toggle flag", d, 32'h0);
    idle(2);
    doRead(1, d);
    chk(d[3] == 1, "R4 flag kept after read", d, 32'h8);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      for (int p = 0; p < 2; p++) begin
        if ($urandom_range(15) == 0) rxLoss[p]    = ~rxLoss[p];
        if ($urandom_range(15) == 0) txFault[p]   = ~txFault[p];
        if ($urandom_range(31) == 0) modAbsent[p] = ~modAbsent[p];
        if ($urandom_range(15) == 0) linkUp[p]    = ~linkUp[p];
      end
      rdEn = ($urandom_range(3) == 0);
      rdPort = 1'($urandom_range(1));
    end
    @(negedge clk); rdEn = 0;
    idle(3);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule